// File: doc/BRIEF.md
# Byte-Multiplexed Flash Address Sequencer

This block turns one parallel memory request into a timed access on an external EEPROM or flash device that shares a single 8-bit bus for address and data. A request carries a 20-bit address, a direction flag, a write byte and a read wait count. The block puts the address on the bus one byte at a time, most significant byte first. For each byte it raises a separate strobe, whose rising edge clocks an external latch that captures that byte. It then either drives the write byte with a write pulse or releases the bus and samples the byte the memory returns.

The upper address nibble goes out first, zero-extended to 8 bits. The middle byte follows, and the lowest byte comes last. Each byte and the write byte occupy a three-clock window: a setup clock, a strobe clock and a hold clock. The bus does not change across the window. A read keeps the bus released for the programmed wait count plus one clock, samples the bus at the end of that time, and then reports completion with a one-clock done pulse.

Top module: `flash_addr_seq`

## Requirements
- R1: After reset, busy, done, bus_oe, mem_we, mem_re and all addr_stb bits are 0.
- R2: A request (req_valid high at a rising clock edge) is accepted only while busy is 0. A request held high while busy is 1 changes neither the running access nor its timing, and is not started afterwards if it is withdrawn before the access ends.
- R3: When a request is accepted at edge 0, bus_out carries {4'h0, addr[19:16]} in cycles 1–3, addr[15:8] in cycles 4–6 and addr[7:0] in cycles 7–9, with bus_oe high in all nine cycles.
- R4: addr_stb[2] is high only in cycle 2, addr_stb[1] only in cycle 5 and addr_stb[0] only in cycle 8. Bit 2 latches addr[19:16], bit 1 latches addr[15:8] and bit 0 latches addr[7:0]. At most one bit is high at a time, and bus_out is the same in the cycle before and the cycle after each strobe cycle.
- R5: In a write, bus_out equals the write byte with bus_oe high in cycles 10–12, and mem_we is high in cycle 11 only.
- R6: In a read with wait count W (0..15), bus_oe is 0 and mem_re is 1 in cycles 10 through 10+W. bus_in is sampled at the edge that ends cycle 10+W.
- R7: done is high for exactly one cycle: cycle 13 for a write, or cycle 11+W for a read. busy is high from cycle 1 through the done cycle and is 0 in the cycle after it.
- R8: rd_data shows the sampled byte in the read's done cycle and keeps it until the next read samples the bus. Writes leave it unchanged.
- R9: mem_re is never high during a write, mem_we is never high during a read, and bus_oe is never high while mem_re is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Memory address |
| req_wdata | input | 8 | Write byte |
| req_wait | input | 4 | Read wait count W |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 8 | Last byte read |
| bus_out | output | 8 | Shared bus drive value |
| bus_in | input | 8 | Shared bus sampled value |
| bus_oe | output | 1 | Shared bus drive enable |
| addr_stb | output | 3 | Per-byte address latch strobes |
| mem_we | output | 1 | Memory write pulse |
| mem_re | output | 1 | Memory output enable during read |

## Verification
The bench builds the block with its default parameters: a 20-bit address, an 8-bit bus and a 4-bit wait field. With these values the address splits into three bytes, one of them a zero-extended nibble, and both ends of the wait range (0 and 15) can be reached. The bench changes bus_in every clock, so a read that samples one clock early or late returns a visibly different byte. A stray request held through a whole access shows whether acceptance is gated by busy.

// File: rtl/fas_pkg.sv
`timescale 1ns/1ps
package fas_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WDAT,
    ST_RDAT,
    ST_DONE
  } fas_state_e;

  typedef logic [1:0] fas_phase_t;
  localparam fas_phase_t PH_SETUP = 2'd0;
  localparam fas_phase_t PH_EDGE  = 2'd1;
  localparam fas_phase_t PH_HOLD  = 2'd2;

  function automatic fas_phase_t next_phase(input fas_phase_t p);
    return (p == PH_HOLD) ? PH_SETUP : fas_phase_t'(p + 2'd1);
  endfunction
endpackage

// File: rtl/fas_addr_mux.sv
`timescale 1ns/1ps
module fas_addr_mux #(
  parameter int ADDR_W = 20,
  parameter int BUS_W  = 8,
  parameter int NB     = 3,
  parameter int IDX_W  = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [IDX_W-1:0]  sel,
  output logic [BUS_W-1:0]  lane
);
  localparam int PAD_W = NB * BUS_W;

  logic [PAD_W-1:0] padded;
  logic [BUS_W-1:0] lanes [NB];

  assign padded = PAD_W'(addr);

  // lane k is presented k-th: most significant byte at k = 0
  for (genvar k = 0; k < NB; k++) begin : g_lane
    assign lanes[k] = padded[(NB-1-k)*BUS_W +: BUS_W];
  end

  always_comb begin
    lane = '0;
    for (int k = 0; k < NB; k++) begin
      if (sel == IDX_W'(k)) lane = lanes[k];
    end
  end
endmodule

// File: rtl/fas_wait_ctr.sv
`timescale 1ns/1ps
module fas_wait_ctr #(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WAIT_W-1:0] load_val,
  input  logic              dec,
  output logic              expired
);
  logic [WAIT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (dec && !expired) cnt_q <= cnt_q - WAIT_W'(1);
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/flash_addr_seq.sv
`timescale 1ns/1ps
module flash_addr_seq
  import fas_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BUS_W  = 8,
  parameter int WAIT_W = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              req_valid,
  input  logic                              req_write,
  input  logic [ADDR_W-1:0]                 req_addr,
  input  logic [BUS_W-1:0]                  req_wdata,
  input  logic [WAIT_W-1:0]                 req_wait,
  output logic                              busy,
  output logic                              done,
  output logic [BUS_W-1:0]                  rd_data,
  output logic [BUS_W-1:0]                  bus_out,
  input  logic [BUS_W-1:0]                  bus_in,
  output logic                              bus_oe,
  output logic [(ADDR_W+BUS_W-1)/BUS_W-1:0] addr_stb,
  output logic                              mem_we,
  output logic                              mem_re
);
  localparam int NB    = (ADDR_W + BUS_W - 1) / BUS_W;
  localparam int IDX_W = (NB > 1) ? $clog2(NB) : 1;

  fas_state_e        state_q;
  fas_phase_t        ph_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BUS_W-1:0]  wd_q;
  logic [BUS_W-1:0]  rd_q;
  logic [WAIT_W-1:0] wait_q;
  logic              wr_q;

  // named internal events
  logic             take_req;
  logic             last_byte;
  logic             addr_end;
  logic             rd_sample;
  logic             wait_over;
  logic [BUS_W-1:0] addr_lane;

  assign take_req  = (state_q == ST_IDLE) && req_valid;
  assign last_byte = (idx_q == IDX_W'(NB-1));
  assign addr_end  = (state_q == ST_ADDR) && (ph_q == PH_HOLD) && last_byte;
  assign rd_sample = (state_q == ST_RDAT) && wait_over;

  fas_addr_mux #(
    .ADDR_W(ADDR_W), .BUS_W(BUS_W), .NB(NB), .IDX_W(IDX_W)
  ) u_mux (
    .addr(addr_q), .sel(idx_q), .lane(addr_lane)
  );

  fas_wait_ctr #(.WAIT_W(WAIT_W)) u_wait (
    .clk(clk), .rst_n(rst_n),
    .load(addr_end && !wr_q), .load_val(wait_q),
    .dec(state_q == ST_RDAT), .expired(wait_over)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ph_q    <= PH_SETUP;
      idx_q   <= '0;
      addr_q  <= '0;
      wd_q    <= '0;
      rd_q    <= '0;
      wait_q  <= '0;
      wr_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (take_req) begin
          addr_q  <= req_addr;
          wd_q    <= req_wdata;
          wr_q    <= req_write;
          wait_q  <= req_wait;
          idx_q   <= '0;
          ph_q    <= PH_SETUP;
          state_q <= ST_ADDR;
        end
        ST_ADDR: begin
          ph_q <= next_phase(ph_q);
          if (ph_q == PH_HOLD) begin
            if (last_byte) state_q <= wr_q ? ST_WDAT : ST_RDAT;
            else           idx_q   <= idx_q + IDX_W'(1);
          end
        end
        ST_WDAT: begin
          ph_q <= next_phase(ph_q);
          if (ph_q == PH_HOLD) state_q <= ST_DONE;
        end
        ST_RDAT: if (rd_sample) begin
          rd_q    <= bus_in;
          state_q <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  for (genvar j = 0; j < NB; j++) begin : g_stb
    assign addr_stb[j] = (state_q == ST_ADDR) && (ph_q == PH_EDGE) &&
                         (idx_q == IDX_W'(NB-1-j));
  end

  always_comb begin
    bus_out = '0;
    if (state_q == ST_ADDR)      bus_out = addr_lane;
    else if (state_q == ST_WDAT) bus_out = wd_q;
  end

  assign bus_oe  = (state_q == ST_ADDR) || (state_q == ST_WDAT);
  assign mem_we  = (state_q == ST_WDAT) && (ph_q == PH_EDGE);
  assign mem_re  = (state_q == ST_RDAT);
  assign busy    = (state_q != ST_IDLE);
  assign done    = (state_q == ST_DONE);
  assign rd_data = rd_q;

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> !busy && !done && !bus_oe && (addr_stb == '0)); // R1
  AST_TAKE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    take_req |=> busy && !done); // R2
  AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(addr_stb)); // R4
  AST_STB_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_stb != '0) |-> bus_oe && $stable(bus_out)); // R4
  AST_STB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_stb != '0) |=> bus_oe && $stable(bus_out)); // R4
  AST_WE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> bus_oe && $stable(bus_out)); // R5
  AST_WE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> bus_oe && $stable(bus_out) && !mem_we); // R5
  AST_RE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> !bus_oe && !mem_we); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy); // R7
  AST_RD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_sample |=> $stable(rd_data)); // R8
endmodule

// File: tb/tb_flash_addr_seq.sv
`timescale 1ns/1ps
module tb_flash_addr_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [19:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic [3:0]  req_wait = '0;
  logic        busy, done, bus_oe, mem_we, mem_re;
  logic [7:0]  rd_data, bus_out;
  logic [7:0]  bus_in = '0;
  logic [2:0]  addr_stb;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit finished = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  flash_addr_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_wait(req_wait),
    .busy(busy), .done(done), .rd_data(rd_data), .bus_out(bus_out),
    .bus_in(bus_in), .bus_oe(bus_oe), .addr_stb(addr_stb),
    .mem_we(mem_we), .mem_re(mem_re)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s at cycle %0d: actual %0h expected %0h",
               req, what, cyc, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_addr_byte(input logic [19:0] a, input int b);
    case (b)
      0:       return {4'h0, a[19:16]};
      1:       return a[15:8];
      default: return a[7:0];
    endcase
  endfunction

  task automatic check_addr_cycle(input int k, input logic [19:0] a);
    int b = (k - 1) / 3;
    int p = (k - 1) % 3;
    logic [2:0] es = (p == 1) ? (3'b100 >> b) : 3'b000;
    chk(bus_oe == 1'b1, "R3", "bus_oe addr", 32'(bus_oe), 32'd1);
    chk(bus_out == exp_addr_byte(a, b), "R3", "addr byte", 32'(bus_out),
        32'(exp_addr_byte(a, b)));
    chk(addr_stb == es, "R4", "addr_stb", 32'(addr_stb), 32'(es));
    chk(busy && !done, "R7", "busy/done addr", {busy, done}, 32'b10);
    chk(!mem_we && !mem_re, "R9", "we/re in addr", {mem_we, mem_re}, 32'd0);
  endtask

  task automatic issue(input bit wr, input logic [19:0] a, input logic [7:0] wd,
                       input logic [3:0] w);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd; req_wait = w;
    @(negedge clk);   // edge 0 passed; now in cycle 1
    req_valid = 1'b0;
  endtask

  // write access; optional stray request held high during cycles 2..12
  task automatic do_write(input logic [19:0] a, input logic [7:0] wd, input bit stray);
    logic [7:0] keep = rd_data;
    issue(1'b1, a, wd, 4'd7);
    for (int k = 1; k <= 14; k++) begin
      if (k <= 9) check_addr_cycle(k, a);
      else if (k <= 12) begin
        chk(bus_oe && bus_out == wd, "R5", "write byte", {bus_oe, bus_out},
            {1'b1, wd});
        chk(mem_we == (k == 11), "R5", "mem_we", 32'(mem_we), 32'(k == 11));
        chk(!mem_re && addr_stb == 3'b0, "R9", "re/stb in write",
            {mem_re, addr_stb}, 32'd0);
      end else if (k == 13) begin
        chk(done && busy, "R7", "write done", {busy, done}, 32'b11);
        chk(rd_data == keep, "R8", "rd_data after write", 32'(rd_data), 32'(keep));
      end else begin
        chk(!done && !busy, "R7", "idle after write", {busy, done}, 32'b00);
      end
      if (stray) begin
        req_valid = (k >= 1 && k < 12);
        req_write = 1'b0; req_addr = ~a; req_wait = 4'd3;
      end
      @(negedge clk);
    end
    if (stray) chk(!busy, "R2", "stray request not started", 32'(busy), 32'd0);
  endtask

  task automatic do_read(input logic [19:0] a, input logic [3:0] w, input logic [7:0] seed);
    int wi = int'(w);
    logic [7:0] exp = 8'(seed + 8'(10 + wi));
    bus_in = seed;
    issue(1'b0, a, 8'hEE, w);
    for (int k = 1; k <= 12 + wi; k++) begin
      if (k <= 9) check_addr_cycle(k, a);
      else if (k <= 10 + wi) begin
        chk(!bus_oe && mem_re, "R6", "read released", {bus_oe, mem_re}, 32'b01);
        chk(!mem_we && !done, "R9", "no we in read", {mem_we, done}, 32'd0);
      end else if (k == 11 + wi) begin
        chk(done && !mem_re, "R7", "read done", {done, mem_re}, 32'b10);
        chk(rd_data == exp, "R6", "sample point", 32'(rd_data), 32'(exp));
      end else begin
        chk(!busy && !done, "R7", "idle after read", {busy, done}, 32'b00);
        chk(rd_data == exp, "R8", "rd_data held", 32'(rd_data), 32'(exp));
      end
      bus_in = 8'(seed + 8'(k));
      @(negedge clk);
    end
  endtask

  task automatic reset_check();
    #5;
    chk(!busy && !done && !bus_oe && !mem_we && !mem_re && addr_stb == 0,
        "R1", "reset outputs", {busy, done, bus_oe, mem_we, mem_re, addr_stb},
        32'd0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not end");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    reset_check();
    do_write(20'hA5C3F, 8'h5A, 1'b0);
    do_read(20'h1F00E, 4'd0, 8'h30);
    do_write(20'h00000, 8'hFF, 1'b1);     // R2 stray request
    do_read(20'hFFFFF, 4'd15, 8'h80);     // R6 longest wait
    do_read(20'h6B2D4, 4'd3, 8'h11);
    do_write(20'h80001, 8'h00, 1'b0);     // R8 held over write
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule